// File: doc/BRIEF.md
# Channel-Scan Conversion Sequencer with DMA Writeback

This block drives an external analog-to-digital converter through a series of conversions and stores every result in memory through a simple request/grant DMA port. Before a run, a host loads four registers while the block is idle:
- a 15-bit memory address,
- a 12-bit word count, written as the negated number of words,
- the channel to convert first,
- the highest channel of the scan.

An automatic run converts one channel at a time. Each result is posted to memory. The address and the count then step together. The channel moves to the next one and returns to 0 after the final channel. The run stops when the count reaches zero.

The same block also performs single programmed conversions. The host starts one conversion and reads the result from a holding register. No DMA transfer takes place in this mode. Programmed conversions and automatic runs may alternate freely. A run may be started at any time the block is idle.

Top module: `scan_dma_seq`

## Requirements
- R1: After a synchronous reset, busy, done, dma_req and conv_start are 0, and rd_addr and rd_chan read 0.
- R2: While busy is 0, a one-cycle load strobe writes the matching register from host_data: the address from bits [14:0], the word count from bits [11:0], and the channel and the final channel from bits [7:0]. The address reads back on rd_addr and the channel on rd_chan in the next cycle.
- R3: While busy is 1, load strobes have no effect on any register.
- R4: A cmd_start pulse in idle sets busy and clears done. One cycle after the pulse, conv_start is high for exactly one cycle, with conv_chan showing the selected channel. When conv_done arrives, the next cycle shows result = conv_data, busy 0, done 1 and no DMA request. The channel then reads its old value plus 1 modulo 256, with no compare against the final channel.
- R5: A cmd_pulse in idle starts an automatic run. One cycle after each conv_done, dma_req is high with dma_addr equal to the current address and dma_data equal to the converted value. All three hold steady until dma_grant is sampled high.
- R6: On the grant cycle, dma_req drops and the address and the count both increment. In the following cycle, conv_start starts the next conversion, unless the run has ended.
- R7: A count loaded as the two's complement of N gives exactly N transfers, and a count of 0 gives 4096. After the last grant, busy is 0, done is 1, and no further conv_start or dma_req appears.
- R8: In an automatic run, after converting channel c, the channel becomes 0 if c equals the final channel, and c+1 otherwise.
- R9: If the final channel is below the starting channel, the channel counts up through 255, wraps to 0 and continues scanning. The transfer count and the addresses are unaffected.
- R10: The memory address wraps from 0x7FFF to 0x0000.
- R11: conv_done outside a conversion is ignored: result, done and rd_chan do not change. cmd_start and cmd_pulse are ignored while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_data | input | 16 | Host write data for register loads |
| ld_addr | input | 1 | Load memory address |
| ld_count | input | 1 | Load negated word count |
| ld_chan | input | 1 | Load channel select |
| ld_final | input | 1 | Load final channel |
| cmd_start | input | 1 | Start one programmed conversion |
| cmd_pulse | input | 1 | Start an automatic DMA run |
| conv_start | output | 1 | One-cycle converter start |
| conv_chan | output | 8 | Channel to convert |
| conv_done | input | 1 | Converter finished, data valid |
| conv_data | input | 16 | Converted value |
| dma_req | output | 1 | Memory write request |
| dma_addr | output | 15 | Memory write address |
| dma_data | output | 16 | Memory write data |
| dma_grant | input | 1 | Memory write accepted |
| busy | output | 1 | Conversion or run in progress |
| done | output | 1 | Last conversion or run finished |
| rd_addr | output | 15 | Current memory address readback |
| rd_chan | output | 8 | Current channel readback |
| result | output | 16 | Last converted value |

## Verification
The bench stresses the scan return at the final channel, a start channel above the final one, an address crossing 0x7FFF, and a zero count that must give 4096 transfers. A design that compared the channel before converting would skip the final channel. A design that tested the count before incrementing would issue one transfer too many or too few. A design whose address did not wrap would write outside the 15-bit space.

Grants are delayed by random amounts, and in that window the bench fires load strobes and start commands. A design that latched them mid-run would write data to a wrong address or end the run at a wrong length. A design that released the request early would lose words. The bench also runs programmed conversions, on channel 255 and on a channel equal to the final channel. A design that applied the scan compare in programmed mode would wrap to 0 instead of counting on.

// File: rtl/scan_pkg.sv
package scan_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CONV = 2'd1,
    ST_XFER = 2'd2
  } seq_state_t;
endpackage

// File: rtl/scan_chan_sel.sv
module scan_chan_sel #(
  parameter int CH_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ld_chan,
  input  logic            ld_final,
  input  logic [CH_W-1:0] din,
  input  logic            step,
  input  logic            scan,
  output logic [CH_W-1:0] chan
);
  logic [CH_W-1:0] fin_q;
  logic            at_final;

  assign at_final = (chan == fin_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      chan  <= '0;
      fin_q <= '0;
    end else begin
      if (ld_final) fin_q <= din;
      if (ld_chan) begin
        chan <= din;
      end else if (step) begin
        // scan mode returns to 0 after the final channel is converted
        if (scan && at_final) chan <= '0;
        else                  chan <= chan + 1'b1;
      end
    end
  end
endmodule

// File: rtl/scan_xfer_ctr.sv
module scan_xfer_ctr #(
  parameter int ADDR_W = 15,
  parameter int WC_W   = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_addr,
  input  logic              ld_count,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [WC_W-1:0]   count_in,
  input  logic              step,
  output logic [ADDR_W-1:0] addr,
  output logic              last_word
);
  logic [WC_W-1:0] wc_q;

  // count is held negated; the word that brings it to zero is the last
  assign last_word = &wc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr <= '0;
      wc_q <= '0;
    end else begin
      if (ld_addr)   addr <= addr_in;
      else if (step) addr <= addr + 1'b1;
      if (ld_count)  wc_q <= count_in;
      else if (step) wc_q <= wc_q + 1'b1;
    end
  end
endmodule

// File: rtl/scan_seq_fsm.sv
module scan_seq_fsm
  import scan_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic cmd_start,
  input  logic cmd_pulse,
  input  logic conv_done,
  input  logic dma_grant,
  input  logic last_word,
  output logic busy,
  output logic done,
  output logic conv_start,
  output logic dma_req,
  output logic auto_mode,
  output logic capture,
  output logic xfer_step
);
  seq_state_t state;

  assign capture   = (state == ST_CONV) && conv_done;
  assign xfer_step = (state == ST_XFER) && dma_grant;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      busy       <= 1'b0;
      done       <= 1'b0;
      conv_start <= 1'b0;
      dma_req    <= 1'b0;
      auto_mode  <= 1'b0;
    end else begin
      conv_start <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (cmd_pulse || cmd_start) begin
            state      <= ST_CONV;
            conv_start <= 1'b1;
            busy       <= 1'b1;
            done       <= 1'b0;
            auto_mode  <= cmd_pulse;
          end
        end
        ST_CONV: begin
          if (conv_done) begin
            if (auto_mode) begin
              state   <= ST_XFER;
              dma_req <= 1'b1;
            end else begin
              state <= ST_IDLE;
              busy  <= 1'b0;
              done  <= 1'b1;
            end
          end
        end
        ST_XFER: begin
          if (dma_grant) begin
            dma_req <= 1'b0;
            if (last_word) begin
              state <= ST_IDLE;
              busy  <= 1'b0;
              done  <= 1'b1;
            end else begin
              state      <= ST_CONV;
              conv_start <= 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/scan_dma_seq.sv
module scan_dma_seq #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 15,
  parameter int WC_W   = 12,
  parameter int CH_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] host_data,
  input  logic              ld_addr,
  input  logic              ld_count,
  input  logic              ld_chan,
  input  logic              ld_final,
  input  logic              cmd_start,
  input  logic              cmd_pulse,
  output logic              conv_start,
  output logic [CH_W-1:0]   conv_chan,
  input  logic              conv_done,
  input  logic [DATA_W-1:0] conv_data,
  output logic              dma_req,
  output logic [ADDR_W-1:0] dma_addr,
  output logic [DATA_W-1:0] dma_data,
  input  logic              dma_grant,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [CH_W-1:0]   rd_chan,
  output logic [DATA_W-1:0] result
);
  logic host_ok, auto_mode, capture, xfer_step, last_word;
  logic [CH_W-1:0] chan;

  assign host_ok   = !busy;
  assign conv_chan = chan;
  assign rd_chan   = chan;

  scan_seq_fsm u_fsm (
    .clk(clk), .rst(rst),
    .cmd_start(cmd_start), .cmd_pulse(cmd_pulse),
    .conv_done(conv_done), .dma_grant(dma_grant), .last_word(last_word),
    .busy(busy), .done(done), .conv_start(conv_start), .dma_req(dma_req),
    .auto_mode(auto_mode), .capture(capture), .xfer_step(xfer_step)
  );

  scan_chan_sel #(.CH_W(CH_W)) u_chan (
    .clk(clk), .rst(rst),
    .ld_chan(ld_chan && host_ok), .ld_final(ld_final && host_ok),
    .din(host_data[CH_W-1:0]),
    .step(capture), .scan(auto_mode),
    .chan(chan)
  );

  scan_xfer_ctr #(.ADDR_W(ADDR_W), .WC_W(WC_W)) u_xfer (
    .clk(clk), .rst(rst),
    .ld_addr(ld_addr && host_ok), .ld_count(ld_count && host_ok),
    .addr_in(host_data[ADDR_W-1:0]), .count_in(host_data[WC_W-1:0]),
    .step(xfer_step),
    .addr(rd_addr), .last_word(last_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result   <= '0;
      dma_addr <= '0;
      dma_data <= '0;
    end else if (capture) begin
      result <= conv_data;
      if (auto_mode) begin
        dma_addr <= rd_addr;
        dma_data <= conv_data;
      end
    end
  end
endmodule

// File: rtl/scan_dma_seq_chk.sv
module scan_dma_seq_chk #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 15,
  parameter int CH_W   = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              conv_start,
  input logic              dma_req,
  input logic [ADDR_W-1:0] dma_addr,
  input logic [DATA_W-1:0] dma_data,
  input logic              dma_grant,
  input logic              busy,
  input logic              done,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [CH_W-1:0]   rd_chan
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    dma_req && !dma_grant |=> dma_req && $stable(dma_addr) && $stable(dma_data)); // R5
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    dma_req && dma_grant |=> rd_addr == ADDR_W'($past(rd_addr) + 1'b1)); // R10
  AST_ADDR_FROZEN: assert property (@(posedge clk) disable iff (rst)
    busy && !(dma_req && dma_grant) |=> $stable(rd_addr)); // R3
  AST_NO_START_IN_XFER: assert property (@(posedge clk) disable iff (rst)
    dma_req |-> !conv_start); // R6
  AST_START_ONE: assert property (@(posedge clk) disable iff (rst)
    conv_start |=> !conv_start); // R4
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst)
    busy |-> !done); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !dma_req && !conv_start); // R7
  AST_CHAN_HOLD: assert property (@(posedge clk) disable iff (rst)
    dma_req |=> $stable(rd_chan)); // R8
endmodule

bind scan_dma_seq scan_dma_seq_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CH_W(CH_W)) u_chk (
  .clk(clk), .rst(rst), .conv_start(conv_start), .dma_req(dma_req),
  .dma_addr(dma_addr), .dma_data(dma_data), .dma_grant(dma_grant),
  .busy(busy), .done(done), .rd_addr(rd_addr), .rd_chan(rd_chan)
);

// File: tb/tb_scan_dma_seq.sv
`timescale 1ns/1ps
module tb_scan_dma_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] host_data = '0;
  logic        ld_addr = 0, ld_count = 0, ld_chan = 0, ld_final = 0;
  logic        cmd_start = 0, cmd_pulse = 0;
  logic        conv_start;
  logic [7:0]  conv_chan;
  logic        conv_done = 0;
  logic [15:0] conv_data = '0;
  logic        dma_req;
  logic [14:0] dma_addr;
  logic [15:0] dma_data;
  logic        dma_grant = 0;
  logic        busy, done;
  logic [14:0] rd_addr;
  logic [7:0]  rd_chan;
  logic [15:0] result;

  int n_run = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  scan_dma_seq dut (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] next_chan(input logic [7:0] c, input logic [7:0] f);
    return (c == f) ? 8'd0 : c + 8'd1;
  endfunction

  task automatic load(input logic [14:0] a, input logic [11:0] wc, input logic [7:0] c, input logic [7:0] f);
    @(negedge clk); host_data = {1'b0, a};  ld_addr  = 1;
    @(negedge clk); ld_addr = 0;  host_data = {4'h0, wc}; ld_count = 1;
    @(negedge clk); ld_count = 0; host_data = {8'h0, c};  ld_chan  = 1;
    @(negedge clk); ld_chan = 0;  host_data = {8'h0, f};  ld_final = 1;
    @(negedge clk); ld_final = 0;
  endtask

  task automatic run_auto(input logic [14:0] a0, input int n, input logic [7:0] c0,
                          input logic [7:0] f, input bit chk_ch, input bit poke);
    logic [14:0] ea;
    logic [7:0]  ec;
    logic [15:0] d;
    bit quiet;
    int g;
    load(a0, 12'(-n), c0, f);
    ea = a0; ec = c0;
    @(negedge clk); cmd_pulse = 1;
    @(negedge clk); cmd_pulse = 0;
    chk(conv_start && busy && !done, "R5 run start", {conv_start, busy, done}, 3'b110);
    for (int i = 0; i < n; i++) begin
      if (chk_ch) chk(conv_chan == ec, "R8 conv channel", conv_chan, ec);
      d = 16'($urandom);
      repeat ($urandom_range(0, 2)) @(negedge clk);
      conv_done = 1; conv_data = d;
      @(negedge clk); conv_done = 0;
      chk(dma_req && dma_addr == ea && dma_data == d, "R5 request", {dma_req, dma_addr, dma_data}, {1'b1, ea, d});
      ec = next_chan(ec, f);
      if (chk_ch) chk(rd_chan == ec, "R8 channel advance", rd_chan, ec);
      g = $urandom_range(0, 2);
      if (poke && i == 1) g = 2;
      for (int k = 0; k < g; k++) begin
        if (poke && i == 1) begin
          host_data = 16'($urandom);
          ld_addr = 1; ld_count = 1; ld_chan = 1; ld_final = 1; cmd_start = 1; cmd_pulse = 1;
        end
        @(negedge clk);
        ld_addr = 0; ld_count = 0; ld_chan = 0; ld_final = 0; cmd_start = 0; cmd_pulse = 0;
        chk(dma_req && dma_addr == ea && dma_data == d, "R5 R3 R11 hold until grant",
            {dma_req, dma_addr, dma_data}, {1'b1, ea, d});
      end
      dma_grant = 1;
      @(negedge clk); dma_grant = 0;
      ea = ea + 15'd1;
      chk(!dma_req && rd_addr == ea, "R6 R10 address step", {dma_req, rd_addr}, {1'b0, ea});
      if (i < n - 1) chk(conv_start && busy, "R6 next start", {conv_start, busy}, 2'b11);
      else           chk(!conv_start && !busy && done, "R7 end of run", {conv_start, busy, done}, 3'b001);
    end
    quiet = 1;
    repeat (5) begin
      @(negedge clk);
      if (conv_start || dma_req || busy) quiet = 0;
    end
    chk(quiet, "R7 quiet after run", quiet, 1);
  endtask

  task automatic run_prog(input logic [7:0] c);
    logic [15:0] d;
    logic [14:0] a;
    load(15'h1234, 12'h000, c, c);
    a = rd_addr;
    @(negedge clk); cmd_start = 1;
    @(negedge clk); cmd_start = 0;
    chk(conv_start && conv_chan == c && busy && !done, "R4 programmed start",
        {conv_start, conv_chan, busy, done}, {1'b1, c, 2'b10});
    @(negedge clk);
    chk(!conv_start, "R4 start is one cycle", conv_start, 0);
    d = 16'($urandom);
    conv_done = 1; conv_data = d;
    @(negedge clk); conv_done = 0;
    chk(!busy && done && result == d && !dma_req, "R4 programmed finish",
        {busy, done, dma_req, result}, {3'b010, d});
    chk(rd_chan == c + 8'd1 && rd_addr == a, "R4 channel plus one", {rd_chan, rd_addr}, {c + 8'd1, a});
  endtask

  initial begin
    logic [15:0] r0;
    logic [7:0]  c0;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(!busy && !done && !dma_req && !conv_start && rd_addr == 0 && rd_chan == 0, "R1 reset state",
        {busy, done, dma_req, conv_start, rd_addr, rd_chan}, 0);

    load(15'h2A5C, 12'hFFD, 8'd17, 8'd40);
    chk(rd_addr == 15'h2A5C && rd_chan == 8'd17, "R2 load readback", {rd_addr, rd_chan}, {15'h2A5C, 8'd17});

    run_prog(8'd9);
    run_prog(8'd255);

    // stray converter completion in idle
    r0 = result; c0 = rd_chan;
    @(negedge clk); conv_done = 1; conv_data = ~r0;
    @(negedge clk); conv_done = 0;
    chk(result == r0 && rd_chan == c0 && done && !busy, "R11 stray done ignored", {result, rd_chan}, {r0, c0});

    run_auto(15'h0100, 7, 8'd2, 8'd4, 1, 1);   // scan wrap at final, busy pokes
    run_prog(8'd30);                           // modes alternate
    run_auto(15'h7FFE, 4, 8'd0, 8'd0, 1, 0);   // address wrap, single-channel scan
    run_auto(15'h0040, 12, 8'd250, 8'd3, 0, 0); // R9 final below start
    for (int r = 0; r < 8; r++) begin
      logic [7:0] s;
      s = 8'($urandom_range(0, 200));
      run_auto(15'($urandom), $urandom_range(1, 24), s, s + 8'($urandom_range(0, 40)), 1, r == 3);
    end
    run_auto(15'h5000, 4096, 8'd0, 8'd7, 1, 0); // zero count gives 4096 words (R7)

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL R7 watchdog actual=hung expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule